// File: doc/BRIEF.md
# In-Order Retirement Buffer with Register Producer Tracking

This block sits between the issue stage and the architectural state of an out-of-order core. Issue places each instruction, in program order, into a circular queue slot. The slot number becomes the instruction's tag. Execution units broadcast their results on a shared result bus, labelled with that tag. Only the queue listens to the bus; the architectural register file never does. The oldest slot retires once its result is complete. A register-writing operation then updates the architectural register file, and a store presents its address and data on a memory write port. Nothing speculative reaches registers or memory before retirement.

A producer table keeps, for each architectural register, a pending flag and the tag of the newest in-flight writer. Issue uses it to resolve source operands through two lookup ports. Each port returns the committed value, or a value already held in the queue, or the tag to wait for. A branch reaches the head with a mispredict flag set by its result broadcast. It then discards every younger slot and clears all pending flags.

Top module: `rob_core`

## Requirements
- R1: After synchronous reset the queue is empty. `issue_ready` is 1, `commit_valid` is 0, every register looks up as ready with value 0, and the next tag is 0.
- R2: Each accepted issue takes the slot at the tail. `issue_tag` shows that slot number before the edge that accepts the issue. Tags count up by one and wrap from DEPTH-1 to 0.
- R3: Once DEPTH slots are occupied, `issue_ready` is 0. An `issue_valid` pulse in that state changes no slot, no tag and no register status.
- R4: Issuing a register writer (`issue_kind` = 2'b00) to register d makes lookups of d return not-ready with the new tag. A later writer to d replaces that tag.
- R5: A bus broadcast with `cdb_is_addr` = 0 fills the data of the slot named by `cdb_tag`. From the next cycle, a lookup of a register waiting on that slot returns ready with the broadcast value, before the slot retires.
- R6: Only the head slot retires, and only when complete. Younger complete slots wait behind an incomplete head. `commit_valid` and `commit_tag` name the slot that retires at the next edge.
- R7: Retiring a register writer writes its value into the architectural register. The pending flag clears only if the register's recorded tag still equals the retiring tag; otherwise the register keeps waiting on the newer writer.
- R8: A store (`issue_kind` = 2'b01) is complete only when it holds both data (broadcast with `cdb_is_addr` = 0) and address (broadcast with `cdb_is_addr` = 1). While it retires, `mem_wr_en` is 1 with that address and data, and no register is written.
- R9: A branch (`issue_kind` = 2'b10) whose data broadcast carried `cdb_mispredict` = 1 raises `commit_flush` as it retires. At that edge all younger slots are discarded, the next tag becomes the branch tag plus one, and every pending flag clears. Discarded stores never write memory. Issue is refused in the flush cycle.
- R10: A branch broadcast with `cdb_mispredict` = 0 retires with `commit_flush` = 0, and the slots behind it go on to retire normally.
- R11: At most one slot retires per cycle. Successive retirements carry consecutive tags in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue request |
| issue_kind | input | 2 | 00 register write, 01 store, 10 branch |
| issue_dst | input | 4 | Destination register (register writers) |
| issue_ready | output | 1 | Issue accepted this cycle if requested |
| issue_tag | output | 3 | Slot the next issue receives |
| src_a_reg | input | 4 | Lookup port A register index |
| src_a_ready | output | 1 | Port A value is usable |
| src_a_value | output | 32 | Port A operand value |
| src_a_tag | output | 3 | Port A producer tag when not ready |
| src_b_reg | input | 4 | Lookup port B register index |
| src_b_ready | output | 1 | Port B value is usable |
| src_b_value | output | 32 | Port B operand value |
| src_b_tag | output | 3 | Port B producer tag when not ready |
| cdb_valid | input | 1 | Result bus broadcast present |
| cdb_tag | input | 3 | Slot the broadcast belongs to |
| cdb_value | input | 32 | Broadcast data or store address |
| cdb_is_addr | input | 1 | 1: value is a store address |
| cdb_mispredict | input | 1 | Branch outcome was mispredicted |
| commit_valid | output | 1 | Head slot retires at the next edge |
| commit_tag | output | 3 | Tag of the retiring slot |
| commit_flush | output | 1 | Retiring branch discards younger slots |
| mem_wr_en | output | 1 | Store write strobe |
| mem_wr_addr | output | 32 | Store address |
| mem_wr_data | output | 32 | Store data |

## Verification
Eight independent register writers fill the queue completely. Their results then arrive youngest first, which shows that retirement waits for the head rather than following arrival order, and that a full queue rejects issue. Two writers to one register, finished oldest first, separate a tag-matched flag clear from an unconditional one. A store that gets its data before its address shows whether both halves are required. A mispredicted branch with finished work behind it is run against a correctly predicted one, to tell a real discard from a spurious one.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int DEPTH = 8;
    localparam int NREGS = 16;
    localparam int XLEN  = 32;

    localparam int TAG_W = $clog2(DEPTH);
    localparam int REG_W = $clog2(NREGS);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef enum logic [1:0] {
        KIND_REG    = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_BRANCH = 2'b10
    } op_kind_e;

    typedef struct packed {
        logic             valid;
        op_kind_e         kind;
        logic [REG_W-1:0] dst;
        logic             data_ok;
        logic             addr_ok;
        logic             mispred;
        logic [XLEN-1:0]  data;
        logic [XLEN-1:0]  addr;
    } slot_t;

    function automatic logic [TAG_W-1:0] next_tag(input logic [TAG_W-1:0] t);
        if (t == TAG_W'(DEPTH - 1)) return '0;
        return t + 1'b1;
    endfunction

    function automatic logic slot_complete(input slot_t s);
        return s.valid && s.data_ok && ((s.kind != KIND_STORE) || s.addr_ok);
    endfunction

endpackage

// File: rtl/rob_regfile.sv
module rob_regfile
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [REG_W-1:0] rd_idx_a,
    input  logic [REG_W-1:0] rd_idx_b,
    output logic [XLEN-1:0]  rd_data_a,
    output logic [XLEN-1:0]  rd_data_b
);

    logic [XLEN-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data_a = regs_q[rd_idx_a];
    assign rd_data_b = regs_q[rd_idx_b];

    // R7: a retiring value lands in its register
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/rob_status.sv
module rob_status
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_reg,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic             flush,
    input  logic [REG_W-1:0] rd_reg_a,
    input  logic [REG_W-1:0] rd_reg_b,
    output logic             busy_a,
    output logic [TAG_W-1:0] tag_a,
    output logic             busy_b,
    output logic [TAG_W-1:0] tag_b
);

    logic [NREGS-1:0] busy_vec;
    logic [TAG_W-1:0] tag_arr [NREGS];

    generate
        for (genvar r = 0; r < NREGS; r++) begin : g_reg
            logic             busy_r;
            logic [TAG_W-1:0] tag_r;
            logic             hit_set;
            logic             hit_clr;

            assign hit_set = set_en && (set_reg == REG_W'(r));
            assign hit_clr = clr_en && (clr_reg == REG_W'(r)) && (tag_r == clr_tag);

            always_ff @(posedge clk) begin
                if (rst) begin
                    busy_r <= 1'b0;
                    tag_r  <= '0;
                end else if (flush) begin
                    busy_r <= 1'b0;
                end else if (hit_set) begin
                    busy_r <= 1'b1;
                    tag_r  <= set_tag;
                end else if (hit_clr) begin
                    busy_r <= 1'b0;
                end
            end

            assign busy_vec[r] = busy_r;
            assign tag_arr[r]  = tag_r;
        end
    endgenerate

    assign busy_a = busy_vec[rd_reg_a];
    assign tag_a  = tag_arr[rd_reg_a];
    assign busy_b = busy_vec[rd_reg_b];
    assign tag_b  = tag_arr[rd_reg_b];

    // R4: newest writer becomes the recorded producer
    assert_issue_marks_R4: assert property (@(posedge clk) disable iff (rst)
        (set_en && !flush) |=> busy_vec[$past(set_reg)] && (tag_arr[$past(set_reg)] == $past(set_tag)));

    // R9: a discard leaves no register pending
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (busy_vec == '0));

endmodule

// File: rtl/rob_queue.sv
module rob_queue
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_en,
    input  op_kind_e         issue_kind,
    input  logic [REG_W-1:0] issue_dst,
    input  logic             cdb_valid,
    input  logic [TAG_W-1:0] cdb_tag,
    input  logic [XLEN-1:0]  cdb_value,
    input  logic             cdb_is_addr,
    input  logic             cdb_mispredict,
    input  logic [TAG_W-1:0] rd_tag_a,
    input  logic [TAG_W-1:0] rd_tag_b,
    output logic             rd_done_a,
    output logic [XLEN-1:0]  rd_data_a,
    output logic             rd_done_b,
    output logic [XLEN-1:0]  rd_data_b,
    output logic [TAG_W-1:0] head_tag,
    output logic [TAG_W-1:0] tail_tag,
    output logic             full,
    output logic             commit_fire,
    output logic             flush,
    output op_kind_e         head_kind,
    output logic [REG_W-1:0] head_dst,
    output logic [XLEN-1:0]  head_data,
    output logic [XLEN-1:0]  head_addr
);

    slot_t            slots_q [DEPTH];
    logic [TAG_W-1:0] head_q;
    logic [TAG_W-1:0] tail_q;
    logic [CNT_W-1:0] count_q;
    slot_t            head_slot;
    slot_t            fresh;

    assign head_slot   = slots_q[head_q];
    assign commit_fire = slot_complete(head_slot);
    assign flush       = commit_fire && (head_slot.kind == KIND_BRANCH) && head_slot.mispred;
    assign full        = (count_q == CNT_W'(DEPTH));

    always_comb begin
        fresh       = '0;
        fresh.valid = 1'b1;
        fresh.kind  = issue_kind;
        fresh.dst   = issue_dst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (flush) begin
            for (int i = 0; i < DEPTH; i++) slots_q[i].valid <= 1'b0;
            head_q  <= next_tag(head_q);
            tail_q  <= next_tag(head_q);
            count_q <= '0;
        end else begin
            if (cdb_valid && slots_q[cdb_tag].valid) begin
                if (cdb_is_addr) begin
                    slots_q[cdb_tag].addr    <= cdb_value;
                    slots_q[cdb_tag].addr_ok <= 1'b1;
                end else begin
                    slots_q[cdb_tag].data    <= cdb_value;
                    slots_q[cdb_tag].data_ok <= 1'b1;
                    slots_q[cdb_tag].mispred <= cdb_mispredict;
                end
            end
            if (commit_fire) begin
                slots_q[head_q].valid <= 1'b0;
                head_q <= next_tag(head_q);
            end
            if (issue_en) begin
                slots_q[tail_q] <= fresh;
                tail_q <= next_tag(tail_q);
            end
            count_q <= count_q + CNT_W'(issue_en) - CNT_W'(commit_fire);
        end
    end

    assign rd_done_a = slots_q[rd_tag_a].valid && slots_q[rd_tag_a].data_ok;
    assign rd_data_a = slots_q[rd_tag_a].data;
    assign rd_done_b = slots_q[rd_tag_b].valid && slots_q[rd_tag_b].data_ok;
    assign rd_data_b = slots_q[rd_tag_b].data;

    assign head_tag  = head_q;
    assign tail_tag  = tail_q;
    assign head_kind = head_slot.kind;
    assign head_dst  = head_slot.dst;
    assign head_data = head_slot.data;
    assign head_addr = head_slot.addr;

    // R3: occupancy never exceeds the slot count
    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    // R11: one retirement moves the head by exactly one slot
    assert_head_step_R11: assert property (@(posedge clk) disable iff (rst)
        commit_fire |=> head_q == next_tag($past(head_q)));

    // R9: a discard leaves the queue empty
    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count_q == '0) && (head_q == tail_q));

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [1:0]       issue_kind,
    input  logic [REG_W-1:0] issue_dst,
    output logic             issue_ready,
    output logic [TAG_W-1:0] issue_tag,
    input  logic [REG_W-1:0] src_a_reg,
    output logic             src_a_ready,
    output logic [XLEN-1:0]  src_a_value,
    output logic [TAG_W-1:0] src_a_tag,
    input  logic [REG_W-1:0] src_b_reg,
    output logic             src_b_ready,
    output logic [XLEN-1:0]  src_b_value,
    output logic [TAG_W-1:0] src_b_tag,
    input  logic             cdb_valid,
    input  logic [TAG_W-1:0] cdb_tag,
    input  logic [XLEN-1:0]  cdb_value,
    input  logic             cdb_is_addr,
    input  logic             cdb_mispredict,
    output logic             commit_valid,
    output logic [TAG_W-1:0] commit_tag,
    output logic             commit_flush,
    output logic             mem_wr_en,
    output logic [XLEN-1:0]  mem_wr_addr,
    output logic [XLEN-1:0]  mem_wr_data
);

    op_kind_e         kind_in;
    logic             issue_en;
    logic [TAG_W-1:0] head_tag;
    logic [TAG_W-1:0] tail_tag;
    logic             full;
    logic             fire;
    logic             flush;
    op_kind_e         head_kind;
    logic [REG_W-1:0] head_dst;
    logic [XLEN-1:0]  head_data;
    logic [XLEN-1:0]  head_addr;
    logic             busy_a, busy_b;
    logic [TAG_W-1:0] ptag_a, ptag_b;
    logic             done_a, done_b;
    logic [XLEN-1:0]  qdata_a, qdata_b;
    logic [XLEN-1:0]  arch_a, arch_b;
    logic             reg_commit;

    assign kind_in     = op_kind_e'(issue_kind);
    assign issue_ready = !full && !flush;
    assign issue_en    = issue_valid && issue_ready;
    assign issue_tag   = tail_tag;
    assign reg_commit  = fire && (head_kind == KIND_REG);

    rob_queue u_queue (
        .clk            (clk),
        .rst            (rst),
        .issue_en       (issue_en),
        .issue_kind     (kind_in),
        .issue_dst      (issue_dst),
        .cdb_valid      (cdb_valid),
        .cdb_tag        (cdb_tag),
        .cdb_value      (cdb_value),
        .cdb_is_addr    (cdb_is_addr),
        .cdb_mispredict (cdb_mispredict),
        .rd_tag_a       (ptag_a),
        .rd_tag_b       (ptag_b),
        .rd_done_a      (done_a),
        .rd_data_a      (qdata_a),
        .rd_done_b      (done_b),
        .rd_data_b      (qdata_b),
        .head_tag       (head_tag),
        .tail_tag       (tail_tag),
        .full           (full),
        .commit_fire    (fire),
        .flush          (flush),
        .head_kind      (head_kind),
        .head_dst       (head_dst),
        .head_data      (head_data),
        .head_addr      (head_addr)
    );

    rob_status u_status (
        .clk      (clk),
        .rst      (rst),
        .set_en   (issue_en && (kind_in == KIND_REG)),
        .set_reg  (issue_dst),
        .set_tag  (tail_tag),
        .clr_en   (reg_commit),
        .clr_reg  (head_dst),
        .clr_tag  (head_tag),
        .flush    (flush),
        .rd_reg_a (src_a_reg),
        .rd_reg_b (src_b_reg),
        .busy_a   (busy_a),
        .tag_a    (ptag_a),
        .busy_b   (busy_b),
        .tag_b    (ptag_b)
    );

    rob_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_commit),
        .wr_idx    (head_dst),
        .wr_data   (head_data),
        .rd_idx_a  (src_a_reg),
        .rd_idx_b  (src_b_reg),
        .rd_data_a (arch_a),
        .rd_data_b (arch_b)
    );

    always_comb begin
        src_a_ready = 1'b1;
        src_a_value = arch_a;
        src_a_tag   = '0;
        if (busy_a) begin
            src_a_tag = ptag_a;
            if (done_a) src_a_value = qdata_a;
            else begin
                src_a_ready = 1'b0;
                src_a_value = '0;
            end
        end
    end

    always_comb begin
        src_b_ready = 1'b1;
        src_b_value = arch_b;
        src_b_tag   = '0;
        if (busy_b) begin
            src_b_tag = ptag_b;
            if (done_b) src_b_value = qdata_b;
            else begin
                src_b_ready = 1'b0;
                src_b_value = '0;
            end
        end
    end

    assign commit_valid = fire;
    assign commit_tag   = head_tag;
    assign commit_flush = flush;
    assign mem_wr_en    = fire && (head_kind == KIND_STORE);
    assign mem_wr_addr  = head_addr;
    assign mem_wr_data  = head_data;

    // R9: no issue is taken in a discard cycle
    assert_no_issue_on_flush_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (tail_tag == head_tag));

endmodule

// File: tb/rob_core_tb_top.sv
`timescale 1ns/1ps
module rob_core_tb_top;
    import rob_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             issue_valid;
    logic [1:0]       issue_kind;
    logic [REG_W-1:0] issue_dst;
    logic             issue_ready;
    logic [TAG_W-1:0] issue_tag;
    logic [REG_W-1:0] src_a_reg, src_b_reg;
    logic             src_a_ready, src_b_ready;
    logic [XLEN-1:0]  src_a_value, src_b_value;
    logic [TAG_W-1:0] src_a_tag, src_b_tag;
    logic             cdb_valid;
    logic [TAG_W-1:0] cdb_tag;
    logic [XLEN-1:0]  cdb_value;
    logic             cdb_is_addr;
    logic             cdb_mispredict;
    logic             commit_valid;
    logic [TAG_W-1:0] commit_tag;
    logic             commit_flush;
    logic             mem_wr_en;
    logic [XLEN-1:0]  mem_wr_addr, mem_wr_data;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    rob_core dut_i (.*);

    // {destination register, result value}
    localparam logic [35:0] VEC [8] = '{
        {4'd1, 32'h0000_1111}, {4'd2, 32'hDEAD_0002}, {4'd3, 32'h0BAD_F00D},
        {4'd4, 32'h8000_0000}, {4'd5, 32'h0000_5555}, {4'd6, 32'hFFFF_FFFF},
        {4'd7, 32'h1234_5678}, {4'd8, 32'h0000_0008}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_issue(input logic [1:0] kind, input logic [REG_W-1:0] dst);
        issue_valid = 1'b1; issue_kind = kind; issue_dst = dst;
        tick;
        issue_valid = 1'b0;
    endtask

    task automatic do_bcast(input logic [TAG_W-1:0] tag, input logic [XLEN-1:0] val,
                            input logic is_addr, input logic mis);
        cdb_valid = 1'b1; cdb_tag = tag; cdb_value = val;
        cdb_is_addr = is_addr; cdb_mispredict = mis;
        tick;
        cdb_valid = 1'b0; cdb_is_addr = 1'b0; cdb_mispredict = 1'b0;
    endtask

    task automatic look(input logic [REG_W-1:0] r);
        src_a_reg = r;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; issue_valid = 1'b0; issue_kind = 2'b00; issue_dst = '0;
        src_a_reg = '0; src_b_reg = '0; cdb_valid = 1'b0; cdb_tag = '0;
        cdb_value = '0; cdb_is_addr = 1'b0; cdb_mispredict = 1'b0;
        repeat (3) tick;
        rst = 1'b0;
        #1;

        // R1 reset state
        chk("R1 issue_ready", 32'(issue_ready), 32'd1);
        chk("R1 commit_valid", 32'(commit_valid), 32'd0);
        chk("R1 next tag", 32'(issue_tag), 32'd0);
        look(4'd3);
        chk("R1 reg ready", 32'(src_a_ready), 32'd1);
        chk("R1 reg value", src_a_value, 32'd0);

        // Vector table: fill the queue with independent writers
        for (int i = 0; i < 8; i++) begin
            chk("R2 allocated tag", 32'(issue_tag), 32'(i));
            do_issue(2'b00, VEC[i][35:32]);
        end
        chk("R3 full blocks", 32'(issue_ready), 32'd0);
        do_issue(2'b00, 4'd15);
        look(4'd15);
        chk("R3 ignored issue status", 32'(src_a_ready), 32'd1);
        chk("R3 ignored issue tag", 32'(issue_tag), 32'd0);
        look(VEC[0][35:32]);
        chk("R4 pending ready", 32'(src_a_ready), 32'd0);
        chk("R4 pending tag", 32'(src_a_tag), 32'd0);

        for (int i = 7; i >= 1; i--) begin
            do_bcast(TAG_W'(i), VEC[i][31:0], 1'b0, 1'b0);
            chk("R6 head blocks younger", 32'(commit_valid), 32'd0);
        end
        look(VEC[7][35:32]);
        chk("R5 forwarded ready", 32'(src_a_ready), 32'd1);
        chk("R5 forwarded value", src_a_value, VEC[7][31:0]);

        do_bcast(3'd0, VEC[0][31:0], 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            chk("R6 retire pending", 32'(commit_valid), 32'd1);
            chk("R11 retire order", 32'(commit_tag), 32'(i));
            tick;
        end
        chk("R11 drained", 32'(commit_valid), 32'd0);
        chk("R2 tag wrapped", 32'(issue_tag), 32'd0);
        for (int i = 0; i < 8; i++) begin
            look(VEC[i][35:32]);
            chk("R7 committed value", src_a_value, VEC[i][31:0]);
        end

        // R4/R7 two writers to one register
        do_issue(2'b00, 4'd2);
        do_issue(2'b00, 4'd2);
        look(4'd2);
        chk("R4 newer tag wins", 32'(src_a_tag), 32'd1);
        do_bcast(3'd0, 32'hAAAA_0000, 1'b0, 1'b0);
        tick;
        look(4'd2);
        chk("R7 stale clear kept busy", 32'(src_a_ready), 32'd0);
        chk("R7 still waits newer", 32'(src_a_tag), 32'd1);
        do_bcast(3'd1, 32'hBBBB_0001, 1'b0, 1'b0);
        look(4'd2);
        chk("R5 forward newer", src_a_value, 32'hBBBB_0001);
        tick;
        src_b_reg = 4'd2;
        look(4'd2);
        chk("R7 final value A", src_a_value, 32'hBBBB_0001);
        chk("R7 final value B", src_b_value, 32'hBBBB_0001);

        // R8 store needs address and data
        chk("R8 store tag", 32'(issue_tag), 32'd2);
        do_issue(2'b01, 4'd0);
        do_bcast(3'd2, 32'h0000_0055, 1'b0, 1'b0);
        chk("R8 data alone not done", 32'(commit_valid), 32'd0);
        do_bcast(3'd2, 32'h0000_0100, 1'b1, 1'b0);
        chk("R8 write strobe", 32'(mem_wr_en), 32'd1);
        chk("R8 write addr", mem_wr_addr, 32'h0000_0100);
        chk("R8 write data", mem_wr_data, 32'h0000_0055);
        tick;
        chk("R8 strobe ends", 32'(mem_wr_en), 32'd0);
        look(4'd0);
        chk("R8 no register write", src_a_value, 32'd0);

        // R9 mispredicted branch
        do_issue(2'b10, 4'd0);
        do_issue(2'b00, 4'd5);
        do_issue(2'b01, 4'd0);
        do_bcast(3'd4, 32'h0000_0077, 1'b0, 1'b0);
        do_bcast(3'd5, 32'h0000_00DD, 1'b0, 1'b0);
        do_bcast(3'd5, 32'h0000_0200, 1'b1, 1'b0);
        chk("R6 branch head blocks", 32'(commit_valid), 32'd0);
        do_bcast(3'd3, 32'd0, 1'b0, 1'b1);
        chk("R9 flush raised", 32'(commit_flush), 32'd1);
        chk("R9 refuse issue", 32'(issue_ready), 32'd0);
        chk("R9 no store at branch", 32'(mem_wr_en), 32'd0);
        tick;
        chk("R9 tail after branch", 32'(issue_tag), 32'd4);
        chk("R9 nothing left", 32'(commit_valid), 32'd0);
        look(4'd5);
        chk("R9 busy cleared", 32'(src_a_ready), 32'd1);
        chk("R9 committed kept", src_a_value, VEC[4][31:0]);
        for (int i = 0; i < 3; i++) begin
            chk("R9 discarded store silent", 32'(mem_wr_en), 32'd0);
            tick;
        end

        // R10 correctly predicted branch
        do_issue(2'b10, 4'd0);
        do_issue(2'b00, 4'd9);
        do_bcast(3'd5, 32'h0000_0099, 1'b0, 1'b0);
        do_bcast(3'd4, 32'd0, 1'b0, 1'b0);
        chk("R10 branch retires", 32'(commit_valid), 32'd1);
        chk("R10 no flush", 32'(commit_flush), 32'd0);
        tick;
        chk("R10 younger survives", 32'(commit_tag), 32'd5);
        chk("R10 younger retires", 32'(commit_valid), 32'd1);
        tick;
        look(4'd9);
        chk("R10 younger value", src_a_value, 32'h0000_0099);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule